// File: doc/BRIEF.md
# Start/Busy Handshake Worker

This block is a subordinate controller that a master state machine hands work to through two plain control wires. The master raises a start request. The worker accepts it when idle and then steps through a fixed three-cycle job. A busy flag tells the master that the job is in progress. The job's content is abstracted into the sequence of work states. Start and busy are plain control pins and carry no data, so there is no valid/ready flow and no back-pressure at this edge.

Busy is released one cycle early: it is already low in the final work cycle, while the worker is still finishing. The final state always returns to idle on the next clock, whatever the inputs are. This guarantees that a master which reacts to the falling busy flag meets an idle worker. A wrapping run counter records every completed job so that the number of runs can be observed from outside.

Top module: `hs_worker`

## Requirements
- R1: A synchronous reset, sampled high on a rising clock edge, puts the worker in idle with `busy_o` low and `runs_o` equal to 0 after that edge.
- R2: While the worker is idle and `start_i` is sampled low, `busy_o` stays low and `runs_o` keeps its value.
- R3: When `start_i` is sampled high while the worker is idle, `busy_o` is high in the very next cycle.
- R4: Each accepted start yields exactly two consecutive cycles with `busy_o` high (1 = busy), and never zero.
- R5: `busy_o` is low during the final work cycle, and the worker is idle in the cycle after that without any condition. If `start_i` is held high continuously, `busy_o` therefore repeats the pattern high, high, low, low.
- R6: `start_i` sampled while busy is high, or in the final work cycle, has no effect. It neither extends nor restarts the job. If `start_i` is still high once the worker is idle again, a new job begins.
- R7: `runs_o` increments by one in the cycle after each falling edge of `busy_o` that is not caused by reset. It wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Job request from the master, sampled every clock edge |
| busy_o | output | 1 | High while the job is in progress, early-released |
| runs_o | output | CNT_W | Count of completed jobs, wrapping |

## Verification
The properties assume that reset is held for at least one full clock edge and that `start_i` is a synchronous level that is stable around the rising edge. Beyond that, `start_i` is unconstrained, so every property must hold for any start pattern, including a start held through a whole job. The stimulus changes `start_i` and `rst` only on falling edges. It mixes sparse, medium and dense start densities with held-high runs and occasional two-cycle resets in the middle of a job. Resets that land on a busy cycle are excluded from the fall-based properties through a past-reset guard.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN_A = 2'd1,
    ST_RUN_B = 2'd2,
    ST_LAST  = 2'd3
  } hsw_state_e;
endpackage

// File: rtl/hsw_sequencer.sv
module hsw_sequencer
  import hsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  output hsw_state_e state_o,
  output logic       busy_o,
  output logic       done_o
);
  hsw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_RUN_A;
      ST_RUN_A: state_d = ST_RUN_B;
      ST_RUN_B: state_d = ST_LAST;
      ST_LAST:  state_d = ST_IDLE;   // unconditional return
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // Early release: busy only in the two middle states, low in the last one
  assign busy_o  = (state_q == ST_RUN_A) || (state_q == ST_RUN_B);
  assign done_o  = (state_q == ST_LAST);
  assign state_o = state_q;
endmodule

// File: rtl/hsw_tally.sv
module hsw_tally #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)        count_q <= '0;
    else if (inc_i) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
endmodule

// File: rtl/hs_worker.sv
module hs_worker
  import hsw_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] runs_o
);
  hsw_state_e cur_state;
  logic       job_done;

  hsw_sequencer u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .state_o (cur_state),
    .busy_o  (busy_o),
    .done_o  (job_done)
  );

  hsw_tally #(.W(CNT_W)) u_tally (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (job_done),
    .count_o (runs_o)
  );
endmodule

// File: rtl/hs_worker_chk.sv
module hs_worker_chk
  import hsw_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_i,
  input logic [CNT_W-1:0] runs_i,
  input hsw_state_e       state_i
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!busy_i && runs_i == '0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_i == ST_IDLE && !start_i) |=> (!busy_i && $stable(runs_i))); // R2

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (state_i == ST_IDLE && start_i) |=> busy_i); // R3

  AST_BUSY_TWO: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy_i) && !$past(rst)) |=> (busy_i ##1 !busy_i)); // R4

  AST_FINAL_RETURN: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_i) && !$past(rst)) |=> (state_i == ST_IDLE && !busy_i)); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_i) && !$past(rst)) |=> (runs_i == CNT_W'($past(runs_i) + 1'b1))); // R7
endmodule

bind hs_worker hs_worker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .busy_i  (busy_o),
  .runs_i  (runs_o),
  .state_i (cur_state)
);

// File: tb/test_hs_worker.sv
module test_hs_worker;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic             busy_o;
  logic [CNT_W-1:0] runs_o;

  int n_chk  = 0;
  int n_fail = 0;
  int m_st   = 0;   // 0 idle, 1 and 2 busy, 3 final
  int m_runs = 0;

  always #5 clk = ~clk;

  hs_worker #(.CNT_W(CNT_W)) i_hs_worker (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .runs_o  (runs_o)
  );

  function automatic int next_st(int s, logic st);
    if (s == 0) return st ? 1 : 0;
    if (s == 3) return 0;
    return s + 1;
  endfunction

  function automatic int exp_busy(int s);
    return (s == 1 || s == 2) ? 1 : 0;
  endfunction

  function automatic string tag_of(int s, logic st, logic r);
    if (r)                return "R1";
    if (s == 0)           return st ? "R3" : "R2";
    if (st)               return "R6";
    if (s == 1)           return "R4";
    return "R5";
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic r, logic st);
    string tg;
    @(negedge clk);
    rst = r;
    start_i = st;
    @(posedge clk);
    tg = tag_of(m_st, st, r);
    if (r) begin
      m_st = 0;
      m_runs = 0;
    end else begin
      if (m_st == 3) m_runs = (m_runs + 1) % (1 << CNT_W);
      m_st = next_st(m_st, st);
    end
    #1;
    check(busy_o === 1'(exp_busy(m_st)), tg, int'(busy_o), exp_busy(m_st));
    check(runs_o === CNT_W'(m_runs), "R7", int'(runs_o), m_runs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int dens;
    void'($urandom(32'd20240611));
    // R1: reset state
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    // R2: idle without start
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    // R3, R4, R5: single pulse
    step(1'b0, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    // R5, R6: start held high, back-to-back jobs
    for (int i = 0; i < 14; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    // R6: pulses only during busy and final cycle
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    // R1: reset in the middle of a job
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    // R7: enough held-high jobs to wrap the counter
    for (int i = 0; i < 4 * ((1 << CNT_W) + 2); i++) step(1'b0, 1'b1);
    // Random phases with varying start density
    for (int i = 0; i < 3000; i++) begin
      dens = ((i / 200) % 3 == 0) ? 10 : (((i / 200) % 3 == 1) ? 50 : 90);
      if ($urandom_range(499) == 0) begin
        step(1'b1, 1'($urandom_range(1)));
        step(1'b1, 1'b0);
      end else begin
        step(1'b0, 1'($urandom_range(99) < dens));
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule